// File: doc/BRIEF.md
# Double-to-Single Round-to-Odd Narrowing Unit

This unit takes a 128-bit register image that holds double-precision values and narrows them to single precision. It never rounds up: the kept bits are truncated, and if anything nonzero was dropped, the lowest kept mantissa bit is forced to one. The narrowed value therefore carries enough information to be rounded again to a smaller format, such as half precision with nearest-even, and land on the same answer as a single direct rounding. The unit is meant to be the first stage of such a two-step narrowing.

The results are placed into a 128-bit destination image according to the instruction shape. A scalar operation converts only the low lane, and a merge control decides whether the rest of the destination is kept or zeroed. A vector operation converts both 64-bit lanes and writes the pair either to the low half, zeroing the high half, or to the high half, keeping the low half. Each accepted operation is registered behind a valid/ready handshake that can take one operation per cycle. The exception conditions it raises are OR-ed into a sticky flag vector, which only reset clears.

Top module: `rto_narrow`

## Requirements
- R1: A finite input whose single-precision exponent is in the normal range keeps its top 23 fraction bits; if any lower bit is nonzero, bit 0 of the result is forced to 1 and the inexact flag is raised; otherwise the result is exact and raises no flag.
- R2: A finite input whose magnitude is beyond the single-precision range produces 0x7F7FFFFF (positive) or 0xFF7FFFFF (negative), never infinity, and raises overflow and inexact.
- R3: A nonzero input below the single normal range is shifted into a subnormal result, with the shifted-out bits OR-ed into bit 0; an input below the smallest subnormal gives mantissa field 1 with the input's sign; underflow is raised only when such a result is also inexact.
- R4: Infinities and signed zeros pass through with their sign and raise no flag; a NaN keeps its sign and the upper 22 payload bits, gets the quiet bit (bit 22) set, and raises invalid only when the input's quiet bit (bit 51) was clear.
- R5: With vec_mode=1 and hi_part=0, lane 0 (source bits 63:0) lands in bits 31:0, lane 1 (source bits 127:64) lands in bits 63:32, and bits 127:64 become zero.
- R6: With vec_mode=1 and hi_part=1, lane 0 lands in bits 95:64, lane 1 lands in bits 127:96, and bits 63:0 keep dst_cur.
- R7: With vec_mode=0, only source bits 63:0 are converted, into bits 31:0; bits 127:32 keep dst_cur when merge_en=1 and become zero when merge_en=0.
- R8: fp_flags is sticky with bit 0 invalid, bit 1 overflow, bit 2 underflow and bit 3 inexact; each accepted operation ORs in the flags of its converted lanes (lane 0 only for scalar) in the cycle its result is registered, and no bit clears except by reset.
- R9: in_ready is high whenever the output register is empty or being drained; an operation is accepted on a cycle with in_valid and in_ready high and appears on dst_new with out_valid in the next cycle; while out_valid is high and out_ready is low, dst_new and out_valid hold.
- R10: For every non-NaN lane, rounding the single-precision result to half precision with nearest-even gives the same half value as rounding the original double directly with nearest-even.
- R11: After reset, out_valid is low, fp_flags is zero and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | The unit can accept an operation this cycle |
| src_vec | input | 128 | Source image, two double-precision lanes |
| dst_cur | input | 128 | Current destination contents |
| vec_mode | input | 1 | 0 = scalar shape, 1 = vector shape |
| hi_part | input | 1 | Vector only: 1 = write the high half |
| merge_en | input | 1 | Scalar only: 1 = keep bits 127:32 of dst_cur |
| out_valid | output | 1 | dst_new holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| dst_new | output | 128 | New destination contents |
| fp_flags | output | 4 | Sticky flags {inexact, underflow, overflow, invalid} |

## Verification
The clocked properties check, on every cycle, the local relations: an inexact lane result has an odd mantissa, an overflowing lane gives the largest finite magnitude, an underflow flag never appears without inexact, the zeroed or kept halves for each placement shape, flags that never fall, and a stalled output that holds. Whether each converted value is numerically right can only be shown by the scenarios, which compare every lane against a truncate-plus-sticky model. They also prove the double-rounding property against half precision over values near the overflow edge, the subnormal edge, NaN payloads and random patterns, all under random back-pressure.

// File: rtl/rto_pkg.sv
// Package: shared format constants and types for the round-to-odd narrowing unit.
// Assumes a binary64 source and a binary32 result in IEEE 754 layout.
package rto_pkg;
    localparam int REG_W    = 128;
    localparam int SRC_EXP  = 11;
    localparam int SRC_MAN  = 52;
    localparam int DST_EXP  = 8;
    localparam int DST_MAN  = 23;
    localparam int SRC_W    = 1 + SRC_EXP + SRC_MAN;
    localparam int DST_W    = 1 + DST_EXP + DST_MAN;
    localparam int SRC_BIAS = (1 << (SRC_EXP - 1)) - 1;
    localparam int DST_BIAS = (1 << (DST_EXP - 1)) - 1;
    localparam int DST_EMAX_FIELD = (1 << DST_EXP) - 2;
    localparam int LANES    = REG_W / SRC_W;
    localparam int GRP_W    = LANES * DST_W;
    localparam int FLAG_W   = 4;

    // Packed so that bit 0 is invalid and bit 3 is inexact.
    typedef struct packed {
        logic nx;
        logic uf;
        logic of;
        logic nv;
    } fp_flags_t;
endpackage

// File: rtl/rto_lane_cvt.sv
// Module: one combinational double-to-single lane with round-to-odd.
// Truncates, ORs every discarded bit into the result LSB, saturates overflow
// to the largest finite value and quiets NaNs. Assumes no flush-to-zero and
// no default-NaN substitution.
module rto_lane_cvt
    import rto_pkg::*;
(
    input  logic [SRC_W-1:0] src_i,
    output logic [DST_W-1:0] res_o,
    output fp_flags_t        flg_o
);
    localparam int EXP_ADJ  = SRC_BIAS - DST_BIAS;
    localparam int NORM_MIN = EXP_ADJ + 1;
    localparam int OVF_MAX  = EXP_ADJ + DST_EMAX_FIELD;
    localparam int DROP     = SRC_MAN - DST_MAN;
    localparam int SIG_W    = SRC_MAN + 1;
    localparam int SH_W     = $clog2(SIG_W + 1);
    localparam int SUB_SPAN = SIG_W - DROP;
    localparam logic [DST_W-2:0] MAX_MAG = {{(DST_EXP-1){1'b1}}, 1'b0, {DST_MAN{1'b1}}};

    logic               sgn;
    logic [SRC_EXP-1:0] exp_f;
    logic [SRC_MAN-1:0] frac_f;
    logic [SRC_EXP-1:0] e_eff;
    logic [SIG_W-1:0]   sig;
    logic [SRC_EXP-1:0] gap;
    logic [SH_W-1:0]    tot;
    logic [SIG_W-1:0]   kept;
    logic [SIG_W-1:0]   lost;
    logic               sticky;

    // Split the source and form the effective exponent and full significand.
    always_comb begin : split_p
        sgn    = src_i[SRC_W-1];
        exp_f  = src_i[SRC_W-2 -: SRC_EXP];
        frac_f = src_i[SRC_MAN-1:0];
        e_eff  = (exp_f == '0) ? SRC_EXP'(1) : exp_f;
        sig    = {(exp_f != '0), frac_f};
    end

    // Classify the value and produce the narrowed result with its flags.
    always_comb begin : cvt_p
        res_o  = '0;
        flg_o  = '0;
        gap    = '0;
        tot    = '0;
        kept   = '0;
        lost   = '0;
        sticky = 1'b0;
        if (exp_f == '1) begin
            if (frac_f != '0) begin
                res_o    = {sgn, {DST_EXP{1'b1}}, 1'b1, frac_f[SRC_MAN-2 -: DST_MAN-1]};
                flg_o.nv = ~frac_f[SRC_MAN-1];
            end else begin
                res_o = {sgn, {DST_EXP{1'b1}}, {DST_MAN{1'b0}}};
            end
        end else if (exp_f == '0 && frac_f == '0) begin
            res_o = {sgn, {(DST_W-1){1'b0}}};
        end else if (e_eff > SRC_EXP'(OVF_MAX)) begin
            res_o    = {sgn, MAX_MAG};
            flg_o.of = 1'b1;
            flg_o.nx = 1'b1;
        end else if (e_eff >= SRC_EXP'(NORM_MIN)) begin
            sticky   = |sig[DROP-1:0];
            res_o    = {sgn, DST_EXP'(e_eff - SRC_EXP'(EXP_ADJ)),
                        sig[SRC_MAN-1 -: DST_MAN-1], sig[DROP] | sticky};
            flg_o.nx = sticky;
        end else begin
            gap = SRC_EXP'(NORM_MIN) - e_eff;
            if (gap >= SRC_EXP'(SUB_SPAN)) begin
                tot = SH_W'(SIG_W);
            end else begin
                tot = SH_W'(DROP) + SH_W'(gap);
            end
            kept     = sig >> tot;
            lost     = sig & ((SIG_W'(1) << tot) - SIG_W'(1));
            sticky   = |lost;
            res_o    = {sgn, {DST_EXP{1'b0}}, kept[DST_MAN-1:1], kept[0] | sticky};
            flg_o.uf = sticky;
            flg_o.nx = sticky;
        end
    end
endmodule

// File: rtl/rto_place.sv
// Module: places the narrowed lanes into the destination image and merges
// the lane flags according to the operation shape. Combinational.
// Assumes lane 0 comes from the low source lane.
module rto_place
    import rto_pkg::*;
(
    input  logic [LANES*DST_W-1:0] lane_res_i,
    input  fp_flags_t [LANES-1:0]  lane_flg_i,
    input  logic [REG_W-1:0]       dst_cur_i,
    input  logic                   vec_i,
    input  logic                   hi_i,
    input  logic                   merge_i,
    output logic [REG_W-1:0]       dst_o,
    output fp_flags_t              flg_o
);
    localparam int HALF = REG_W / 2;

    fp_flags_t [LANES-1:0] acc;

    // Build the destination image for the three placement shapes.
    always_comb begin : place_p
        if (vec_i) begin
            if (hi_i) begin
                dst_o = {lane_res_i[GRP_W-1:0], dst_cur_i[HALF-1:0]};
            end else begin
                dst_o = {{(REG_W-GRP_W){1'b0}}, lane_res_i[GRP_W-1:0]};
            end
        end else if (merge_i) begin
            dst_o = {dst_cur_i[REG_W-1:DST_W], lane_res_i[DST_W-1:0]};
        end else begin
            dst_o = {{(REG_W-DST_W){1'b0}}, lane_res_i[DST_W-1:0]};
        end
    end

    // Chain the lane flags; scalar operations stop at lane 0.
    assign acc[0] = lane_flg_i[0];
    for (genvar g = 1; g < LANES; g++) begin : g_acc
        assign acc[g] = acc[g-1] | lane_flg_i[g];
    end

    // Select the flags that the shape actually produced.
    always_comb begin : flg_p
        flg_o = vec_i ? acc[LANES-1] : acc[0];
    end
endmodule

// File: rtl/rto_narrow.sv
// Module: top of the narrowing unit. One round-to-odd converter per 64-bit
// lane, destination placement, one registered output stage behind a
// valid/ready handshake and sticky flags. Synchronous active-low reset.
module rto_narrow
    import rto_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [REG_W-1:0]  src_vec,
    input  logic [REG_W-1:0]  dst_cur,
    input  logic              vec_mode,
    input  logic              hi_part,
    input  logic              merge_en,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [REG_W-1:0]  dst_new,
    output logic [FLAG_W-1:0] fp_flags
);
    logic [LANES*DST_W-1:0] lane_res;
    fp_flags_t [LANES-1:0]  lane_flg;
    logic [REG_W-1:0]       placed;
    fp_flags_t              op_flg;
    logic                   accept;
    logic [REG_W-1:0]       dst_q;
    fp_flags_t              flg_q;
    logic                   vld_q;

    // One converter per source lane.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        rto_lane_cvt u_cvt (
            .src_i (src_vec[l*SRC_W +: SRC_W]),
            .res_o (lane_res[l*DST_W +: DST_W]),
            .flg_o (lane_flg[l])
        );

        // R1: an inexact lane result always has an odd mantissa.
        p_odd_inexact_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_flg[l].nx) |-> lane_res[l*DST_W]);

        // R2: overflow saturates to the largest finite magnitude, same sign.
        p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_flg[l].of) |->
            (lane_res[l*DST_W +: DST_W-1] == 31'h7F7F_FFFF &&
             lane_res[l*DST_W + DST_W-1] == src_vec[l*SRC_W + SRC_W-1]));

        // R3: underflow only with inexact and a zero exponent field.
        p_uf_tiny_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_flg[l].uf) |->
            (lane_flg[l].nx && lane_res[l*DST_W + DST_MAN +: DST_EXP] == '0));
    end

    rto_place u_place (
        .lane_res_i (lane_res),
        .lane_flg_i (lane_flg),
        .dst_cur_i  (dst_cur),
        .vec_i      (vec_mode),
        .hi_i       (hi_part),
        .merge_i    (merge_en),
        .dst_o      (placed),
        .flg_o      (op_flg)
    );

    // The stage takes a new operation when it is empty or being drained.
    always_comb begin : hs_p
        in_ready = ~vld_q | out_ready;
        accept   = in_valid & in_ready;
    end

    // Output register, valid bit and sticky flag accumulation.
    always_ff @(posedge clk) begin : stage_p
        if (!rst_n) begin
            vld_q <= 1'b0;
            dst_q <= '0;
            flg_q <= '0;
        end else begin
            if (in_ready) begin
                vld_q <= in_valid;
            end
            if (accept) begin
                dst_q <= placed;
                flg_q <= flg_q | op_flg;
            end
        end
    end

    assign out_valid = vld_q;
    assign dst_new   = dst_q;
    assign fp_flags  = flg_q;

    // R5: low-half vector write clears the high half.
    p_vec_lo_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && vec_mode && !hi_part) |=> (dst_new[REG_W-1:REG_W/2] == '0));

    // R6: high-half vector write keeps the low half of the old destination.
    p_vec_hi_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && vec_mode && hi_part) |=>
        (dst_new[REG_W/2-1:0] == $past(dst_cur[REG_W/2-1:0])));

    // R7: scalar without merge zeroes everything above the result.
    p_scalar_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !vec_mode && !merge_en) |=> (dst_new[REG_W-1:DST_W] == '0));

    // R8: no sticky flag ever falls.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(fp_flags) & ~fp_flags) == '0));

    // R9: an accepted operation shows up in the next cycle.
    p_accept_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R9: a stalled result holds.
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(dst_new) && $stable(fp_flags)));
endmodule

// File: tb/rto_narrow_tb.sv
// Bench: behavioural truncate-plus-sticky model, placement model, sticky
// flag model and a half-precision double-rounding check, under random stalls.
module rto_narrow_tb;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic         in_ready;
    logic [127:0] src_vec;
    logic [127:0] dst_cur;
    logic         vec_mode;
    logic         hi_part;
    logic         merge_en;
    logic         out_valid;
    logic         out_ready;
    logic [127:0] dst_new;
    logic [3:0]   fp_flags;

    always #5 clk = ~clk;

    rto_narrow u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .src_vec   (src_vec),
        .dst_cur   (dst_cur),
        .vec_mode  (vec_mode),
        .hi_part   (hi_part),
        .merge_en  (merge_en),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .dst_new   (dst_new),
        .fp_flags  (fp_flags)
    );

    typedef struct {
        logic [127:0] src;
        logic [127:0] old;
        logic         vec;
        logic         hi;
        logic         mrg;
    } op_t;

    typedef struct {
        logic [127:0] img;
        op_t          op;
    } exp_t;

    op_t  ops[$];
    exp_t expq[$];
    int   total = 0;
    int   bad   = 0;
    logic [3:0] model_fl;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // Generic rounding of a normalised significand (leading one at bit 63).
    function automatic void narrow(input logic s, input int ex, input logic [63:0] sig,
                                   input int mb, input int emin, input int emax,
                                   input int ew, input bit odd,
                                   output logic [63:0] w, output logic [3:0] fl);
        int sh; int e; int bias; int expf;
        logic [63:0] kept; logic [63:0] rem; logic [63:0] half;
        bit up; bit tiny; bit nx;
        fl = '0; e = ex; sh = 63 - mb; tiny = 0; up = 0;
        bias = (1 << (ew - 1)) - 1;
        if (ex < emin) begin
            sh = sh + (emin - ex); e = emin; tiny = 1;
        end
        if (sh >= 64) begin
            kept = '0; rem = sig;
        end else begin
            kept = sig >> sh; rem = sig & ((64'd1 << sh) - 64'd1);
        end
        nx = (rem != 0);
        if (odd) begin
            if (nx) kept[0] = 1'b1;
        end else begin
            if (sh <= 64) begin
                half = 64'd1 << (sh - 1);
                up = (rem > half) || (rem == half && kept[0]);
            end
            kept = kept + 64'(up);
            if (kept[mb+1]) begin
                kept = kept >> 1; e = e + 1;
            end
        end
        if (e > emax) begin
            fl[1] = 1'b1; fl[3] = 1'b1;
            if (odd) w = (64'((1 << ew) - 2) << mb) | ((64'd1 << mb) - 64'd1);
            else     w = 64'((1 << ew) - 1) << mb;
        end else begin
            expf = kept[mb] ? e + bias : 0;
            w = (64'(expf) << mb) | (kept & ((64'd1 << mb) - 64'd1));
            fl[3] = nx;
            fl[2] = tiny && nx;
        end
        w = w | (64'(s) << (ew + mb));
    endfunction

    function automatic void dec64(input logic [63:0] x, output int ex, output logic [63:0] sig);
        if (x[62:52] == 0) begin
            sig = {x[51:0], 12'b0}; ex = -1022;
            while (!sig[63]) begin sig = sig << 1; ex--; end
        end else begin
            sig = {1'b1, x[51:0], 11'b0}; ex = int'(x[62:52]) - 1023;
        end
    endfunction

    function automatic void dec32(input logic [31:0] y, output int ex, output logic [63:0] sig);
        if (y[30:23] == 0) begin
            sig = {y[22:0], 41'b0}; ex = -126;
            while (!sig[63]) begin sig = sig << 1; ex--; end
        end else begin
            sig = {1'b1, y[22:0], 40'b0}; ex = int'(y[30:23]) - 127;
        end
    endfunction

    // Reference double -> single, round to odd; fl = {nx, uf, of, nv}.
    function automatic void ref32(input logic [63:0] x, output logic [31:0] r, output logic [3:0] fl);
        int ex; logic [63:0] sig; logic [63:0] w;
        fl = '0;
        if (x[62:52] == 11'h7FF) begin
            if (x[51:0] != 0) begin
                r = {x[63], 8'hFF, 1'b1, x[50:29]}; fl[0] = ~x[51];
            end else r = {x[63], 8'hFF, 23'b0};
        end else if (x[62:0] == 0) begin
            r = {x[63], 31'b0};
        end else begin
            dec64(x, ex, sig);
            narrow(x[63], ex, sig, 23, -126, 127, 8, 1'b1, w, fl);
            r = w[31:0];
        end
    endfunction

    function automatic logic [15:0] half_from64(input logic [63:0] x);
        int ex; logic [63:0] sig; logic [63:0] w; logic [3:0] fl;
        if (x[62:52] == 11'h7FF) return {x[63], 15'h7C00};
        if (x[62:0] == 0) return {x[63], 15'h0};
        dec64(x, ex, sig);
        narrow(x[63], ex, sig, 10, -14, 15, 5, 1'b0, w, fl);
        return w[15:0];
    endfunction

    function automatic logic [15:0] half_from32(input logic [31:0] y);
        int ex; logic [63:0] sig; logic [63:0] w; logic [3:0] fl;
        if (y[30:23] == 8'hFF) return {y[31], 15'h7C00};
        if (y[30:0] == 0) return {y[31], 15'h0};
        dec32(y, ex, sig);
        narrow(y[31], ex, sig, 10, -14, 15, 5, 1'b0, w, fl);
        return w[15:0];
    endfunction

    function automatic string lane_tag(input logic [63:0] x, input logic [3:0] fl);
        if (x[62:52] == 11'h7FF || x[62:0] == 0) return "R4";
        if (fl[1]) return "R2";
        if (x[62:52] < 11'd897) return "R3";
        return "R1";
    endfunction

    function automatic logic [63:0] gen64();
        logic [63:0] v;
        int k;
        v = {$urandom, $urandom};
        k = $urandom_range(0, 5);
        case (k)
            1: v[62:52] = 11'($urandom_range(1140, 1160));
            2: v[62:52] = 11'($urandom_range(860, 905));
            3: v[62:52] = 11'($urandom_range(0, 3));
            4: begin
                v[62:52] = ($urandom_range(0, 1) == 1) ? 11'h7FF : 11'h0;
                if ($urandom_range(0, 1) == 1) v[51:0] = '0;
            end
            5: begin
                v[62:52] = 11'($urandom_range(1000, 1050));
                if ($urandom_range(0, 1) == 1) v[28:0] = '0;
            end
            default: ;
        endcase
        return v;
    endfunction

    function automatic op_t mk(input logic [63:0] a, input logic [63:0] b,
                               input logic v, input logic h, input logic m);
        op_t o;
        o.src = {b, a};
        o.old = {$urandom, $urandom, $urandom, $urandom};
        o.vec = v; o.hi = h; o.mrg = m;
        return o;
    endfunction

    // Model of one accepted operation: expected image and its flags.
    function automatic void model(input op_t o, output logic [127:0] img, output logic [3:0] fl);
        logic [31:0] r0; logic [31:0] r1; logic [3:0] f0; logic [3:0] f1;
        ref32(o.src[63:0], r0, f0);
        ref32(o.src[127:64], r1, f1);
        if (o.vec) begin
            fl  = f0 | f1;
            img = o.hi ? {r1, r0, o.old[63:0]} : {64'b0, r1, r0};
        end else begin
            fl  = f0;
            img = o.mrg ? {o.old[127:32], r0} : {96'b0, r0};
        end
    endfunction

    task automatic check_out(input exp_t e);
        int base; int nl;
        string ptag;
        ptag = e.op.vec ? (e.op.hi ? "R6" : "R5") : "R7";
        chk(dst_new == e.img, ptag, "placed image", dst_new, e.img);
        nl   = e.op.vec ? 2 : 1;
        base = (e.op.vec && e.op.hi) ? 64 : 0;
        for (int l = 0; l < nl; l++) begin
            logic [63:0] x; logic [31:0] got; logic [31:0] want; logic [3:0] fl;
            x   = e.op.src[l*64 +: 64];
            got = dst_new[base + l*32 +: 32];
            ref32(x, want, fl);
            chk(got == want, lane_tag(x, fl), "lane value", 128'(got), 128'(want));
            if (!(x[62:52] == 11'h7FF && x[51:0] != 0)) begin
                // R10: two-step narrowing equals direct narrowing to half
                chk(half_from32(got) == half_from64(x), "R10", "double rounding",
                    128'(half_from32(got)), 128'(half_from64(x)));
            end
        end
    endtask

    initial begin
        logic [63:0] dv[16];
        bit          fire_in;
        bit          fire_out;
        bit          held;
        logic [127:0] held_val;
        int          cyc;
        exp_t        e;
        logic [3:0]  fl;

        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        src_vec = '0; dst_cur = '0; vec_mode = 1'b0; hi_part = 1'b0; merge_en = 1'b0;
        model_fl = '0; held = 0; held_val = '0; fire_in = 0; cyc = 0;

        dv[0]  = 64'h3FF0_0000_0000_0000;  // 1.0, exact
        dv[1]  = 64'h3FF0_0000_0000_0001;  // inexact, LSB forced
        dv[2]  = 64'h3FF0_0000_2000_0000;  // exact with LSB set
        dv[3]  = 64'h7FEF_FFFF_FFFF_FFFF;  // largest double, overflow
        dv[4]  = 64'hFFEF_FFFF_FFFF_FFFF;  // negative overflow
        dv[5]  = 64'h0000_0000_0000_0001;  // smallest double subnormal
        dv[6]  = 64'h36A0_0000_0000_0000;  // 2^-149 exact
        dv[7]  = 64'h3800_0000_0000_0000;  // 2^-127 exact subnormal
        dv[8]  = 64'h36A8_0000_0000_0000;  // 1.5 * 2^-149
        dv[9]  = 64'h7FF0_0000_0000_0001;  // signalling NaN
        dv[10] = 64'hFFF8_0000_0000_0000;  // quiet NaN, negative
        dv[11] = 64'h7FF4_0000_0000_0000;  // signalling NaN with payload
        dv[12] = 64'h7FF0_0000_0000_0000;  // +inf
        dv[13] = 64'h8000_0000_0000_0000;  // -0
        dv[14] = 64'h47EF_FFFF_E000_0000;  // largest single, exact
        dv[15] = 64'h47EF_FFFF_F000_0000;  // just above largest single

        for (int i = 0; i < 16; i++) begin
            ops.push_back(mk(dv[i], dv[15-i], 1'b1, 1'b0, 1'b0));
            ops.push_back(mk(dv[i], dv[(i+5)%16], 1'b1, 1'b1, 1'b0));
            ops.push_back(mk(dv[i], dv[i], 1'b0, 1'b0, 1'b1));
            ops.push_back(mk(dv[i], dv[i], 1'b0, 1'b0, 1'b0));
        end
        for (int i = 0; i < 600; i++) begin
            ops.push_back(mk(gen64(), gen64(), 1'($urandom_range(0, 1)),
                             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1))));
        end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid after reset", 128'(out_valid), 128'(0));
        chk(fp_flags == 4'h0, "R11", "flags after reset", 128'(fp_flags), 128'(0));
        chk(in_ready == 1'b1, "R11", "in_ready after reset", 128'(in_ready), 128'(1));

        while ((ops.size() > 0 || in_valid || expq.size() > 0) && cyc < 50000) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            // R8: flags equal the OR of everything accepted so far
            chk(fp_flags == model_fl, "R8", "sticky flags", 128'(fp_flags), 128'(model_fl));
            if (held) begin
                chk(out_valid && dst_new == held_val, "R9", "stalled output held",
                    dst_new, held_val);
            end
            out_ready = ($urandom_range(0, 3) != 0);
            if (!in_valid || fire_in) begin
                if (ops.size() > 0) begin
                    op_t o;
                    o = ops.pop_front();
                    in_valid = 1'b1;
                    src_vec = o.src; dst_cur = o.old;
                    vec_mode = o.vec; hi_part = o.hi; merge_en = o.mrg;
                end else begin
                    in_valid = 1'b0;
                end
            end
            #1;
            chk(in_ready == (!out_valid || out_ready), "R9", "in_ready rule",
                128'(in_ready), 128'(!out_valid || out_ready));
            fire_out = out_valid && out_ready;
            fire_in  = in_valid && in_ready;
            if (fire_out) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected result", dst_new, '0);
                end else begin
                    check_out(expq.pop_front());
                end
            end
            if (fire_in) begin
                e.op.src = src_vec; e.op.old = dst_cur;
                e.op.vec = vec_mode; e.op.hi = hi_part; e.op.mrg = merge_en;
                model(e.op, e.img, fl);
                expq.push_back(e);
                model_fl = model_fl | fl;
            end
            held = out_valid && !out_ready;
            held_val = dst_new;
        end

        if (cyc >= 50000) begin
            chk(1'b0, "R9", "watchdog expired", 128'(cyc), 128'(0));
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule